// File: doc/BRIEF.md
# Virtually Tagged Direct-Mapped Cache with Process Tags

This block is a small direct-mapped cache that is looked up with virtual addresses only. No translation happens before the access. The line index and the tag both come from the virtual address. A current process identifier is held inside the block and is loaded on a context switch. A compile-time mode decides how the cache keeps two address spaces apart:

- **PID mode:** each line remembers the identifier of the process that filled it, and that identifier must match for a hit.
- **Flush mode:** a context switch drops every line in a single cycle.

Reads that hit return data combinationally in the lookup cycle. A read miss stalls the requester and raises a refill request that carries the line-aligned virtual address and the current identifier. The refill is answered with a whole block and a one-cycle valid strobe. Writes go straight through to memory every time. A write hit also updates the cached copy, and a write miss allocates nothing.

Top module: `vtag_cache`

## Requirements
- R1: After reset every line is invalid, no refill is requested, the current process identifier is 0, and the first read of any address misses.
- R2: A read that hits asserts `cpu_hit`, keeps `cpu_stall` low and returns the cached word in the same cycle. Byte-offset bits inside a block do not affect which line is used.
- R3: A read miss asserts `cpu_stall`. From the next cycle `fill_req` is high, with `fill_addr` equal to the request address with its offset bits cleared and `fill_pid` equal to the current identifier. Both are held stable until `fill_valid`.
- R4: On `fill_valid` the block, tag, identifier and valid bit are installed. `fill_req` drops in the next cycle, and the held read hits then. With a one-cycle refill answer, a read miss costs exactly two stall cycles.
- R5: With `FLUSH_MODE`=0, a hit also needs the line's stored identifier to equal the current one. The same virtual address under another identifier misses. Lines of a suspended process survive a switch away and back.
- R6: With `FLUSH_MODE`=1, a context switch invalidates all lines at its clock edge, so every later read misses, even under the same identifier.
- R7: The cache is write-through with no allocation on a write miss.
  - Every accepted write pulses `mem_wr` in its own cycle with the address, data and current identifier, without stalling.
  - A write hit updates the cached word.
  - A write miss leaves the cache unchanged.
- R8: In a cycle with `ctx_switch` high, a request is stalled and no memory write is issued. The current identifier takes `ctx_pid` at that edge. `ctx_switch` is ignored while a refill is pending.
- R9: The line index is the address bits just above the block offset. Two addresses with the same index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until not stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Virtual byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word of the indexed line |
| cpu_hit | output | 1 | Lookup hit this cycle |
| cpu_stall | output | 1 | Request not completed this cycle |
| ctx_switch | input | 1 | Context switch strobe |
| ctx_pid | input | PID_W | Identifier of the incoming process |
| mem_wr | output | 1 | Write-through strobe |
| mem_waddr | output | ADDR_W | Write-through virtual address |
| mem_wdata | output | 32 | Write-through data |
| mem_wpid | output | PID_W | Write-through process identifier |
| fill_req | output | 1 | Refill request pending |
| fill_addr | output | ADDR_W | Line-aligned virtual address to refill |
| fill_pid | output | PID_W | Identifier for the refill |
| fill_valid | input | 1 | Refill block present |
| fill_data | input | BLOCK_BYTES*8 | Refill block |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- a read hit never stalls;
- a read miss is followed by a refill request for the aligned line;
- that request holds steady until answered and drops after the answer;
- writes never stall and always reach memory;
- a switch cycle stalls and blocks writes;
- in flush mode, nothing hits right after a switch.

Only the bench scenarios can show which data comes back:
- that a process sees its own block and not another's;
- that a suspended process's lines survive;
- that a write hit changes the cached word while a write miss allocates nothing;
- that conflicting addresses evict each other.

// File: rtl/vtag_cache.sv
`timescale 1ns/1ps
module vtag_cache #(
  parameter int ADDR_W      = 32,
  parameter int LINES       = 4,
  parameter int BLOCK_BYTES = 4,
  parameter int PID_W       = 4,
  parameter bit FLUSH_MODE  = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic [ADDR_W-1:0]        cpu_addr,
  input  logic [31:0]              cpu_wdata,
  output logic [31:0]              cpu_rdata,
  output logic                     cpu_hit,
  output logic                     cpu_stall,
  input  logic                     ctx_switch,
  input  logic [PID_W-1:0]         ctx_pid,
  output logic                     mem_wr,
  output logic [ADDR_W-1:0]        mem_waddr,
  output logic [31:0]              mem_wdata,
  output logic [PID_W-1:0]         mem_wpid,
  output logic                     fill_req,
  output logic [ADDR_W-1:0]        fill_addr,
  output logic [PID_W-1:0]         fill_pid,
  input  logic                     fill_valid,
  input  logic [BLOCK_BYTES*8-1:0] fill_data
);
  localparam int BLK_W  = BLOCK_BYTES * 8;
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WORDS  = BLOCK_BYTES / 4;
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [PID_W-1:0] pid_q  [LINES];
  logic [BLK_W-1:0] data_q [LINES];

  logic             miss_q;
  logic [TAG_W-1:0] mtag_q;
  logic [IDX_W-1:0] midx_q;
  logic [PID_W-1:0] cur_pid;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  logic [BLK_W-1:0]  blk;
  logic              line_hit, accept, rd_miss;

  assign idx  = cpu_addr[OFF_W +: IDX_W];
  assign tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign wsel = WSEL_W'((cpu_addr >> 2) & ADDR_W'(WORDS - 1));
  assign blk  = data_q[idx];

  assign line_hit = valid_q[idx] && (tag_q[idx] == tag) &&
                    (FLUSH_MODE || (pid_q[idx] == cur_pid));
  assign accept   = cpu_req && !miss_q && !ctx_switch;
  assign rd_miss  = accept && !cpu_we && !line_hit;

  assign cpu_hit   = accept && line_hit;
  assign cpu_rdata = blk[wsel*32 +: 32];
  assign cpu_stall = miss_q || (cpu_req && ctx_switch) || rd_miss;

  assign mem_wr    = accept && cpu_we;
  assign mem_waddr = cpu_addr;
  assign mem_wdata = cpu_wdata;
  assign mem_wpid  = cur_pid;

  assign fill_req  = miss_q;
  assign fill_addr = {mtag_q, midx_q, {OFF_W{1'b0}}};
  assign fill_pid  = cur_pid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      miss_q  <= 1'b0;
      cur_pid <= '0;
    end else if (miss_q) begin
      if (fill_valid) begin
        miss_q          <= 1'b0;
        valid_q[midx_q] <= 1'b1;
      end
    end else if (ctx_switch) begin
      cur_pid <= ctx_pid;
      if (FLUSH_MODE) valid_q <= '0;
    end else if (rd_miss) begin
      miss_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_miss) begin
      mtag_q <= tag;
      midx_q <= idx;
    end
    if (miss_q && fill_valid) begin
      tag_q[midx_q]  <= mtag_q;
      pid_q[midx_q]  <= cur_pid;
      data_q[midx_q] <= fill_data;
    end else if (cpu_hit && cpu_we) begin
      data_q[idx][wsel*32 +: 32] <= cpu_wdata;
    end
  end
endmodule

// File: rtl/vtag_cache_chk.sv
`timescale 1ns/1ps
module vtag_cache_chk #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 4,
  parameter int PID_W       = 4,
  parameter bit FLUSH_MODE  = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_hit,
  input logic              cpu_stall,
  input logic              ctx_switch,
  input logic              mem_wr,
  input logic              fill_req,
  input logic [ADDR_W-1:0] fill_addr,
  input logic [PID_W-1:0]  fill_pid,
  input logic              fill_valid
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLOCK_BYTES - 1);

  p_hit_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit && !cpu_we |-> !cpu_stall);

  p_miss_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_we && !ctx_switch && !fill_req && cpu_stall |=>
      fill_req && (fill_addr == ($past(cpu_addr) & ~OFF_MASK)));

  p_fill_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_valid |=> fill_req && $stable(fill_addr) && $stable(fill_pid));

  p_fill_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && fill_valid |=> !fill_req);

  p_write_thru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && !ctx_switch && !fill_req |-> mem_wr && !cpu_stall);

  p_switch_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && ctx_switch |-> cpu_stall && !mem_wr && !cpu_hit);

  if (FLUSH_MODE) begin : g_flush
    p_flush_cold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_switch && !fill_req |=> !cpu_hit);
  end
endmodule

bind vtag_cache vtag_cache_chk #(
  .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .PID_W(PID_W), .FLUSH_MODE(FLUSH_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .ctx_switch(ctx_switch), .mem_wr(mem_wr),
  .fill_req(fill_req), .fill_addr(fill_addr), .fill_pid(fill_pid), .fill_valid(fill_valid)
);

// File: tb/vtag_cache_tb.sv
`timescale 1ns/1ps
module vtag_cache_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sel;
  logic cpu_req, cpu_we, ctx_switch;
  logic [31:0] cpu_addr, cpu_wdata;
  logic [3:0]  ctx_pid;

  logic [31:0] p_rdata, f_rdata, p_waddr, f_waddr, p_wdata, f_wdata, p_faddr, f_faddr;
  logic        p_hit, f_hit, p_stall, f_stall, p_wr, f_wr, p_freq, f_freq;
  logic [3:0]  p_wpid, f_wpid, p_fpid, f_fpid;
  logic        p_fval, f_fval;
  logic [31:0] p_fdata, f_fdata;

  int nchk = 0, nbad = 0;

  function automatic logic [31:0] model(input logic [31:0] a, input logic [3:0] pid);
    return {pid, a[27:0]};
  endfunction

  vtag_cache #(.FLUSH_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req && !sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(p_rdata), .cpu_hit(p_hit),
    .cpu_stall(p_stall), .ctx_switch(ctx_switch && !sel), .ctx_pid(ctx_pid),
    .mem_wr(p_wr), .mem_waddr(p_waddr), .mem_wdata(p_wdata), .mem_wpid(p_wpid),
    .fill_req(p_freq), .fill_addr(p_faddr), .fill_pid(p_fpid),
    .fill_valid(p_fval), .fill_data(p_fdata));

  vtag_cache #(.FLUSH_MODE(1'b1)) u_dut_f (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req && sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(f_rdata), .cpu_hit(f_hit),
    .cpu_stall(f_stall), .ctx_switch(ctx_switch && sel), .ctx_pid(ctx_pid),
    .mem_wr(f_wr), .mem_waddr(f_waddr), .mem_wdata(f_wdata), .mem_wpid(f_wpid),
    .fill_req(f_freq), .fill_addr(f_faddr), .fill_pid(f_fpid),
    .fill_valid(f_fval), .fill_data(f_fdata));

  wire [31:0] o_rdata = sel ? f_rdata : p_rdata;
  wire        o_hit   = sel ? f_hit   : p_hit;
  wire        o_stall = sel ? f_stall : p_stall;
  wire        o_wr    = sel ? f_wr    : p_wr;
  wire [31:0] o_waddr = sel ? f_waddr : p_waddr;
  wire [31:0] o_wdata = sel ? f_wdata : p_wdata;
  wire [3:0]  o_wpid  = sel ? f_wpid  : p_wpid;
  wire        o_freq  = sel ? f_freq  : p_freq;
  wire [31:0] o_faddr = sel ? f_faddr : p_faddr;
  wire [3:0]  o_fpid  = sel ? f_fpid  : p_fpid;

  // refill responders: answer one cycle after the request appears
  initial begin
    p_fval = 1'b0; p_fdata = '0;
    forever begin
      @(negedge clk);
      p_fval  = p_freq && !p_fval;
      p_fdata = model(p_faddr, p_fpid);
    end
  end
  initial begin
    f_fval = 1'b0; f_fdata = '0;
    forever begin
      @(negedge clk);
      f_fval  = f_freq && !f_fval;
      f_fdata = model(f_faddr, f_fpid);
    end
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // op 0 read, 1 write, 2 context switch (v = new pid); called at a negedge
  task automatic do_op(input int op, input logic [31:0] a, input logic [31:0] v,
                       output logic hit0, output logic [31:0] data, output int stalls,
                       output logic [31:0] faddr, output logic [3:0] fpid,
                       output logic wr0, output logic [31:0] waddr,
                       output logic [31:0] wdat, output logic [3:0] wpid);
    stalls = 0; faddr = 32'hxxxxxxxx; fpid = 4'hx;
    cpu_req = 1'b1; cpu_addr = a; cpu_wdata = v;
    if (op == 2) begin
      cpu_we = 1'b1; ctx_switch = 1'b1; ctx_pid = v[3:0];
      #1; hit0 = o_hit; wr0 = o_wr; stalls = int'(o_stall); data = o_rdata;
      waddr = o_waddr; wdat = o_wdata; wpid = o_wpid;
      @(posedge clk); @(negedge clk);
      ctx_switch = 1'b0;
    end else begin
      cpu_we = (op == 1);
      #1; hit0 = o_hit; wr0 = o_wr; waddr = o_waddr; wdat = o_wdata; wpid = o_wpid;
      while (o_stall && stalls < 20) begin
        if (o_freq) begin faddr = o_faddr; fpid = o_fpid; end
        @(posedge clk); @(negedge clk); #1;
        stalls++;
      end
      data = o_rdata;
      @(posedge clk); @(negedge clk);
    end
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  // row: {op[1:0], addr[31:0], val[31:0], exp_hit, exp_data[31:0], req[3:0]}
  localparam int N = 16;
  localparam logic [102:0] TBL [N] = '{
    {2'd0, 32'h100, 32'h0,        1'b0, 32'h0000_0100, 4'd3}, // R3 cold miss
    {2'd0, 32'h100, 32'h0,        1'b1, 32'h0000_0100, 4'd2}, // R2 hit
    {2'd0, 32'h104, 32'h0,        1'b0, 32'h0000_0104, 4'd4}, // R4 refill
    {2'd1, 32'h104, 32'hDEAD0001, 1'b1, 32'h0,         4'd7}, // R7 write hit
    {2'd0, 32'h104, 32'h0,        1'b1, 32'hDEAD0001,  4'd7}, // R7 updated word
    {2'd1, 32'h208, 32'h11112222, 1'b0, 32'h0,         4'd7}, // R7 write miss
    {2'd0, 32'h208, 32'h0,        1'b0, 32'h0000_0208, 4'd7}, // R7 not allocated
    {2'd0, 32'h20B, 32'h0,        1'b1, 32'h0000_0208, 4'd2}, // R2 offset ignored
    {2'd2, 32'h0,   32'h3,        1'b0, 32'h0,         4'd8}, // R8 switch to 3
    {2'd0, 32'h100, 32'h0,        1'b0, 32'h3000_0100, 4'd5}, // R5 other pid misses
    {2'd2, 32'h0,   32'h0,        1'b0, 32'h0,         4'd8}, // R8 switch to 0
    {2'd0, 32'h104, 32'h0,        1'b1, 32'hDEAD0001,  4'd5}, // R5 line survived
    {2'd0, 32'h100, 32'h0,        1'b0, 32'h0000_0100, 4'd5}, // R5 replaced by pid 3
    {2'd0, 32'h110, 32'h0,        1'b0, 32'h0000_0110, 4'd9}, // R9 conflict
    {2'd0, 32'h100, 32'h0,        1'b0, 32'h0000_0100, 4'd9}, // R9 evicted
    {2'd0, 32'h110, 32'h0,        1'b0, 32'h0000_0110, 4'd9}  // R9 evicted
  };

  task automatic run_row(input logic [102:0] row, inout logic [3:0] pid);
    logic hit0, wr0; logic [31:0] data, faddr, waddr, wdat; logic [3:0] fpid, wpid; int st;
    int op; logic [31:0] a, v, ed; logic eh; string r;
    op = int'(row[102:101]); a = row[100:69]; v = row[68:37]; eh = row[36];
    ed = row[35:4]; r = $sformatf("R%0d", row[3:0]);
    do_op(op, a, v, hit0, data, st, faddr, fpid, wr0, waddr, wdat, wpid);
    if (op == 2) begin
      check({r, " switch stalls"}, 32'(st), 32'd1);
      check({r, " switch blocks write"}, 32'(wr0), 32'd0);
      pid = v[3:0];
    end else if (op == 1) begin
      check({r, " write hit flag"}, 32'(hit0), 32'(eh));
      check({r, " write no stall"}, 32'(st), 32'd0);
      check({r, " mem_wr"}, 32'(wr0), 32'd1);
      check({r, " mem addr"}, waddr, a);
      check({r, " mem data"}, wdat, v);
      check({r, " mem pid"}, 32'(wpid), 32'(pid));
    end else begin
      check({r, " hit flag"}, 32'(hit0), 32'(eh));
      check({r, " read data"}, data, ed);
      check({r, " stall cycles"}, 32'(st), eh ? 32'd0 : 32'd2);
      if (!eh) begin
        check({r, " fill addr"}, faddr, a & ~32'h3);
        check({r, " fill pid"}, 32'(fpid), 32'(pid));
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [3:0] pid;
    rst_n = 1'b0; sel = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; ctx_switch = 1'b0;
    ctx_pid = '0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 no fill after reset", 32'(o_freq), 32'd0);
    check("R1 no stall idle", 32'(o_stall), 32'd0);
    check("R1 no write idle", 32'(o_wr), 32'd0);
    @(negedge clk);
    pid = 4'd0;
    for (int i = 0; i < N; i++) run_row(TBL[i], pid);

    // flush-mode instance: R6
    sel = 1'b1; pid = 4'd0;
    run_row({2'd0, 32'h100, 32'h0, 1'b0, 32'h0000_0100, 4'd1}, pid); // R1 cold
    run_row({2'd0, 32'h100, 32'h0, 1'b1, 32'h0000_0100, 4'd2}, pid);
    run_row({2'd0, 32'h104, 32'h0, 1'b0, 32'h0000_0104, 4'd4}, pid);
    run_row({2'd2, 32'h0,   32'h0, 1'b0, 32'h0,         4'd6}, pid); // R6 same pid
    run_row({2'd0, 32'h100, 32'h0, 1'b0, 32'h0000_0100, 4'd6}, pid);
    run_row({2'd2, 32'h0,   32'h5, 1'b0, 32'h0,         4'd6}, pid); // R6 new pid
    run_row({2'd0, 32'h104, 32'h0, 1'b0, 32'h5000_0104, 4'd6}, pid);
    run_row({2'd0, 32'h100, 32'h0, 1'b0, 32'h5000_0100, 4'd6}, pid);
    #1;
    check("R4 no fill left pending", 32'(o_freq), 32'd0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule